// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a peripheral has left wedged, for example after the host was reset part-way through a transfer. A one-cycle start request makes the block take control of both bus lines. It drives them as open-drain outputs, where a pull-low enable of 0 lets the line float high. It first tries a pseudo-stop: SDA is pulled low and then released while SCL stays high. That edge looks like a bus condition that makes peripherals abandon a pending write. If SDA or SCL is not high at that point, the block gives one clock pulse, which finishes a stuck address acknowledge, and then checks the lines again.

After that the block always sends a fixed burst of nine clock pulses, which flushes any byte a peripheral is still shifting out. It does not watch SCL during this burst. It then makes one last pseudo-stop attempt, releases both lines and reports completion. Every step lasts a whole number of half periods. The half period is a parameter counted in system clock cycles; the default of 250 cycles gives about 100 kHz from a 50 MHz clock. Each line is sampled through a two-flop synchronizer at the end of the half period that comes before a decision.

Top module: `i2c_bus_unstick`

## Requirements
- R1: During reset and after it, both pull-low enables are 0, and busy and done are 0.
- R2: A start request seen while idle raises busy on the next clock edge. Both lines then stay released for exactly one half period, and both synchronized levels are sampled at its end.
- R3: A pseudo-stop happens only when both sampled levels are high. It pulls SDA low for one half period and then releases SDA for one half period, with SCL released throughout.
- R4: If the first check fails, SCL is pulled low for one half period and released for one half period. The lines are then checked again, and a pseudo-stop follows only if both are high.
- R5: After the first pseudo-stop, or after the recovery pulse and the second check, exactly nine SCL pulses follow. Each pulse is one half period low and one half period released, and this happens whatever level SCL reads.
- R6: After the ninth pulse both lines are checked once more, and a final pseudo-stop is sent if both are high.
- R7: When the sequence ends, busy falls, done is 1 for exactly one cycle, and both lines are released.
- R8: A start request made while busy has no effect on the sequence or on its length.
- R9: A line is pulled low only while busy, and SCL and SDA are never pulled low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the recovery sequence |
| scl_i | input | 1 | Level read from the SCL pin |
| sda_i | input | 1 | Level read from the SDA pin |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence finishes |

## Verification
The bench wires each line as an open-drain wired-AND of the block and a model peripheral. The peripheral holds SDA low until it has seen a chosen number of SCL pulses. With a release count of zero, all three checks pass, and the run shows both pseudo-stops with no recovery pulse. A count of one makes only the first check fail, so the recovery pulse and the retried pseudo-stop appear. A count of five makes both early checks fail but lets the SDA release land inside the flush, so only the final pseudo-stop is sent. An SDA that never releases, and an SCL held low for the whole run, both remove every pseudo-stop, and they show that the nine-pulse flush still runs in full. A start request issued in the middle of a run checks that the expected waveform and its length stay the same.

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int HALF_CYC     = 250,
  parameter int FLUSH_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int PW = $clog2(FLUSH_PULSES + 1);

  typedef enum logic [3:0] {
    IDLE, CHECK, PSA_LO, PSA_HI, RC_LO, RC_HI, FL_LO, FL_HI, PSB_LO, PSB_HI
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulses;
  logic [1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, tick, both_hi, last_pulse;

  assign scl_s      = scl_sync[1];
  assign sda_s      = sda_sync[1];
  assign tick       = (cnt == CW'(HALF_CYC - 1));
  assign both_hi    = scl_s & sda_s;
  assign last_pulse = (pulses == PW'(FLUSH_PULSES - 1));
  assign busy_o     = (st != IDLE);

  always_comb begin
    nxt = st;
    case (st)
      IDLE:   if (start_i) nxt = CHECK;
      CHECK:  if (tick) nxt = both_hi ? PSA_LO : RC_LO;
      PSA_LO: if (tick) nxt = PSA_HI;
      PSA_HI: if (tick) nxt = FL_LO;
      RC_LO:  if (tick) nxt = RC_HI;
      RC_HI:  if (tick) nxt = both_hi ? PSA_LO : FL_LO;
      FL_LO:  if (tick) nxt = FL_HI;
      FL_HI:  if (tick) nxt = !last_pulse ? FL_LO : (both_hi ? PSB_LO : IDLE);
      PSB_LO: if (tick) nxt = PSB_HI;
      PSB_HI: if (tick) nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync   <= 2'b11;
      sda_sync   <= 2'b11;
      st         <= IDLE;
      cnt        <= '0;
      pulses     <= '0;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      scl_sync   <= {scl_sync[0], scl_i};
      sda_sync   <= {sda_sync[0], sda_i};
      st         <= nxt;
      cnt        <= (st == IDLE || tick) ? '0 : cnt + 1'b1;
      if (st == IDLE)
        pulses <= '0;
      else if (st == FL_HI && tick)
        pulses <= pulses + 1'b1;
      scl_pull_o <= (nxt == RC_LO) || (nxt == FL_LO);
      sda_pull_o <= (nxt == PSA_LO) || (nxt == PSB_LO);
      done_o     <= (st != IDLE) && (nxt == IDLE);
    end
  end

  AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2
  AST_PS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_s && sda_s)); // R3
  AST_FLUSH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PW'(FLUSH_PULSES)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !scl_pull_o && !sda_pull_o)); // R7
  AST_PULL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o || sda_pull_o) |-> busy_o); // R9
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_pull_o && sda_pull_o)); // R9
endmodule

// File: tb/tb_i2c_bus_unstick.sv
module tb_i2c_bus_unstick;
  localparam int H = 6;

  typedef struct {
    bit    s;
    bit    d;
    bit    b;
    bit    dn;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic scl_pull_o, sda_pull_o, busy_o, done_o;
  logic scl_stuck = 0;
  int   rel = 0, npulses = 0, base = 0;
  bit   prev_pull = 0, chk_en = 0;
  int   n_chk = 0, n_fail = 0, cycles = 0;
  exp_t q[$];

  wire scl_i = ~scl_pull_o & ~scl_stuck;
  wire sda_i = ~sda_pull_o & ~((npulses - base) < rel);

  i2c_bus_unstick #(.HALF_CYC(H), .FLUSH_PULSES(9)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .busy_o(busy_o), .done_o(done_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    prev_pull <= scl_pull_o;
    if (scl_pull_o && !prev_pull) npulses <= npulses + 1;
    cycles <= cycles + 1;
  end

  task automatic check(string tag, bit s, bit d, bit b, bit dn);
    n_chk++;
    if ({scl_pull_o, sda_pull_o, busy_o, done_o} !== {s, d, b, dn}) begin
      n_fail++;
      $display("FAIL %s: scl/sda/busy/done actual %b%b%b%b expected %b%b%b%b",
               tag, scl_pull_o, sda_pull_o, busy_o, done_o, s, d, b, dn);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, e.s, e.d, e.b, e.dn);
      end else
        check("R8 idle", 0, 0, 0, 0);
    end
  end

  task automatic push_half(bit s, bit d, string tag);
    for (int i = 0; i < H; i++) q.push_back('{s, d, 1'b1, 1'b0, tag});
  endtask

  task automatic push_ps(string tag);
    push_half(0, 1, tag);
    push_half(0, 0, tag);
  endtask

  task automatic build(bit stuck, int r);
    int p = 0;
    push_half(0, 0, "R2");
    if (!stuck && r <= p) push_ps("R3");
    else begin
      push_half(1, 0, "R4");
      push_half(0, 0, "R4");
      p = 1;
      if (!stuck && r <= p) push_ps("R4");
    end
    for (int k = 0; k < 9; k++) begin
      push_half(1, 0, "R5");
      push_half(0, 0, "R5");
    end
    p += 9;
    if (!stuck && r <= p) push_ps("R6");
    q.push_back('{1'b0, 1'b0, 1'b0, 1'b1, "R7"});
  endtask

  task automatic run(bit stuck, int r, bit mid_start);
    @(negedge clk);
    scl_stuck = stuck;
    base = npulses;
    rel = r;
    repeat (4) @(negedge clk);
    start_i = 1;
    @(posedge clk);
    build(stuck, r);
    #1 start_i = 0;
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start_i = 1; // R8
      @(negedge clk);
      start_i = 0;
    end
    while (q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 0, 0, 0, 0);
    chk_en = 1;
    run(0, 0, 0);   // clean bus: R3, R6
    run(0, 1, 0);   // SDA frees after one pulse: R4
    run(0, 5, 0);   // SDA frees in flush: R5, R6
    run(0, 99, 0);  // SDA never frees
    run(1, 0, 0);   // SCL held low: flush still runs, R5
    run(0, 0, 1);   // restart while busy: R8
    scl_stuck = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule